// File: doc/BRIEF.md
# Masked Instruction Address Breakpoint

This block watches the instruction fetch stream of a processor core and signals a debug break when a fetch address matches a programmed breakpoint. The compare covers address bits 31:1 only. A programmable mask can exclude any of those bits from the compare, so one breakpoint can cover an aligned range or a strided set of addresses. Bit 0 of the fetch address never takes part in the compare. A separate enable bit arms the breakpoint.

Software programs the block through a small 32-bit register port with three words: breakpoint address, enable and mask. The fetch address and its valid strobe pass through the block unchanged to the downstream memory path. When a valid fetch matches an armed breakpoint, the block pulses a registered hit one cycle later. The pulse comes with the instruction-break cause code and a fixed channel number. Combining this cause with other debug causes, and the response of the core, are handled elsewhere.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, every register word reads 0 and the hit, cause and channel outputs are 0.
- R2: Word 0 (sel=0) holds the breakpoint address in bits 31:1. Bit 0 reads as 0 and writes to it are ignored.
- R3: Word 1 (sel=1) holds the enable in bit 0. Bits 31:1 read as 0.
- R4: Word 2 (sel=2) holds the compare mask in bits 31:1. Bit 0 reads as 0 and writes to it are ignored.
- R5: Word 3 (sel=3) is unused. It reads as 0 and writes to it have no effect on any other word.
- R6: A valid fetch whose unmasked address bits 31:1 equal the breakpoint sets the hit high in the cycle after the fetch, for that one cycle only.
- R7: While the enable bit is 0, no hit is produced.
- R8: A fetch address presented without the valid strobe produces no hit.
- R9: A mask bit of 1 removes that address bit from the compare. A difference on any bit whose mask bit is 0 prevents a hit.
- R10: Fetch address bit 0 has no effect on the match.
- R11: The cause output is 0x02 and the channel output is 0 while the hit is high. Both are 0 otherwise.
- R12: The fetch valid and address outputs equal their inputs in the same cycle, whether or not the fetch matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected word |
| fetch_vld_i | input | 1 | Fetch valid from the core |
| fetch_addr_i | input | 32 | Fetch address from the core |
| fetch_vld_o | output | 1 | Fetch valid to the memory path |
| fetch_addr_o | output | 32 | Fetch address to the memory path |
| brk_hit_o | output | 1 | One-cycle instruction break hit |
| brk_cause_o | output | 5 | Debug cause code while hit is high |
| brk_chan_o | output | 4 | Breakpoint channel number while hit is high |

## Verification
On every cycle, the embedded assertions check three things. First, a hit always follows a valid fetch made while the breakpoint was enabled. Second, the address of that fetch agreed with the breakpoint on every unmasked bit. Third, the cause and channel outputs accompany the hit and are 0 without it. Register readback formatting is also checked continuously: bit 0 of words 0 and 2 reads as 0, and word 3 reads as 0. Only the directed scenarios can show that a hit actually occurs when it should. These scenarios cover exact matches, matches that differ only in bit 0, masked matches, and single-cycle pulse width. They also show that writes to ignored bits leave other state untouched.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned CAUSE_W  = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_IBRK = 5'h02;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADDR = 2'd0,
    SEL_EN   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } ibrk_sel_e;
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [AW-1:1]    brk_addr,
  output logic             brk_en,
  output logic [AW-1:1]    brk_mask
);
  logic [AW-1:1] addr_q, addr_d;
  logic [AW-1:1] mask_q, mask_d;
  logic          en_q, en_d;
  logic          addr_ce, en_ce, mask_ce;

  always_comb begin
    addr_ce = we && (sel == SEL_ADDR);
    en_ce   = we && (sel == SEL_EN);
    mask_ce = we && (sel == SEL_MASK);
    addr_d  = wdata[AW-1:1];
    mask_d  = wdata[AW-1:1];
    en_d    = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (addr_ce) addr_q <= addr_d;
      if (mask_ce) mask_q <= mask_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (ibrk_sel_e'(sel))
      SEL_ADDR: rdata[AW-1:0] = {addr_q, 1'b0};
      SEL_EN:   rdata[0]      = en_q;
      SEL_MASK: rdata[AW-1:0] = {mask_q, 1'b0};
      default:  rdata         = '0;
    endcase
  end

  assign brk_addr = addr_q;
  assign brk_en   = en_q;
  assign brk_mask = mask_q;

  AST_ADDR_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ADDR) |-> (rdata[0] == 1'b0)); // R2
  AST_EN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_EN) |-> (rdata[CFG_W-1:1] == '0)); // R3
  AST_MASK_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MASK) |-> (rdata[0] == 1'b0)); // R4
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (rdata == '0)); // R5
endmodule

// File: rtl/ibrk_match.sv
module ibrk_match #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:1] brk_addr,
  input  logic          brk_en,
  input  logic [AW-1:1] brk_mask,
  output logic          hit
);
  logic [AW-1:1] bit_ok;
  logic          all_ok;
  logic          hit_d, hit_q;

  for (genvar b = 1; b < AW; b++) begin : g_bit
    assign bit_ok[b] = brk_mask[b] | ~(fetch_addr[b] ^ brk_addr[b]);
  end

  always_comb begin
    all_ok = &bit_ok;
    hit_d  = fetch_vld & brk_en & all_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  assign hit = hit_q;

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(fetch_vld)); // R8
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(brk_en)); // R7
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned CHAN_W  = 4,
  parameter int unsigned CHAN_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  input  logic               fetch_vld_i,
  input  logic [AW-1:0]      fetch_addr_i,
  output logic               fetch_vld_o,
  output logic [AW-1:0]      fetch_addr_o,
  output logic               brk_hit_o,
  output logic [CAUSE_W-1:0] brk_cause_o,
  output logic [CHAN_W-1:0]  brk_chan_o
);
  localparam logic [CHAN_W-1:0] CHAN_VAL = CHAN_W'(CHAN_ID);

  logic          rst_s1, rst_s2;
  logic          rst_s_n;
  logic [AW-1:1] brk_addr;
  logic [AW-1:1] brk_mask;
  logic          brk_en;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_s_n = rst_s2;

  ibrk_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .brk_addr (brk_addr),
    .brk_en   (brk_en),
    .brk_mask (brk_mask)
  );

  ibrk_match #(.AW(AW)) u_match (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .fetch_vld  (fetch_vld_i),
    .fetch_addr (fetch_addr_i),
    .brk_addr   (brk_addr),
    .brk_en     (brk_en),
    .brk_mask   (brk_mask),
    .hit        (hit)
  );

  always_comb begin
    fetch_vld_o  = fetch_vld_i;
    fetch_addr_o = fetch_addr_i;
    brk_hit_o    = hit;
    brk_cause_o  = hit ? CAUSE_IBRK : '0;
    brk_chan_o   = hit ? CHAN_VAL : '0;
  end

  AST_HIT_MATCHED: assert property (@(posedge clk) disable iff (!rst_s_n)
    brk_hit_o |-> ((($past(fetch_addr_i[AW-1:1]) ^ $past(brk_addr)) & ~$past(brk_mask)) == '0)); // R9
  AST_CAUSE_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (brk_cause_o != '0) |-> (brk_hit_o && brk_cause_o == CAUSE_IBRK && brk_chan_o == CHAN_VAL)); // R11
endmodule

// File: tb/tb_ibrk_unit.sv
`timescale 1ns/1ps
module tb_ibrk_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        fetch_vld_i;
  logic [31:0] fetch_addr_i;
  logic        fetch_vld_o;
  logic [31:0] fetch_addr_o;
  logic        brk_hit_o;
  logic [4:0]  brk_cause_o;
  logic [3:0]  brk_chan_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ibrk_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i),
    .fetch_vld_o(fetch_vld_o), .fetch_addr_o(fetch_addr_o),
    .brk_hit_o(brk_hit_o), .brk_cause_o(brk_cause_o), .brk_chan_o(brk_chan_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_check(string req, logic [1:0] sel, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic fetch(string req, logic vld, logic [31:0] addr, logic exp_hit);
    @(negedge clk);
    fetch_vld_i = vld; fetch_addr_i = addr;
    #1;
    check("R12 vld", {31'b0, fetch_vld_o}, {31'b0, vld});
    check("R12 addr", fetch_addr_o, addr);
    @(negedge clk);
    fetch_vld_i = 1'b0; fetch_addr_i = '0;
    #1;
    check(req, {31'b0, brk_hit_o}, {31'b0, exp_hit});
    check("R11 cause", {27'b0, brk_cause_o}, exp_hit ? 32'h2 : 32'h0);
    check("R11 chan", {28'b0, brk_chan_o}, 32'h0);
    @(negedge clk);
    #1;
    check("R6 single cycle", {31'b0, brk_hit_o}, 32'h0);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) rd_check("R1 regs", 2'(s), 32'h0);
    check("R1 hit", {31'b0, brk_hit_o}, 32'h0);
    check("R1 cause", {27'b0, brk_cause_o}, 32'h0);
    check("R1 chan", {28'b0, brk_chan_o}, 32'h0);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R2 addr lsb", 2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check("R3 enable", 2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_00FF);
    rd_check("R4 mask lsb", 2'd2, 32'h0000_00FE);
    wr(2'd3, 32'hA5A5_A5A5);
    rd_check("R5 spare", 2'd3, 32'h0);
    rd_check("R5 addr kept", 2'd0, 32'hFFFF_FFFE);
    rd_check("R5 en kept", 2'd1, 32'h1);
    rd_check("R5 mask kept", 2'd2, 32'h0000_00FE);
  endtask

  task automatic t_exact();
    wr(2'd0, 32'h0000_1231);
    wr(2'd2, 32'h0);
    wr(2'd1, 32'h1);
    fetch("R6 exact hit", 1'b1, 32'h0000_1230, 1'b1);
    fetch("R9 unmasked mismatch", 1'b1, 32'h0000_1234, 1'b0);
    fetch("R9 high bit mismatch", 1'b1, 32'h8000_1230, 1'b0);
  endtask

  task automatic t_bit0();
    fetch("R10 bit0 set", 1'b1, 32'h0000_1231, 1'b1);
  endtask

  task automatic t_mask();
    wr(2'd2, 32'h0000_000C);
    fetch("R9 masked hit a", 1'b1, 32'h0000_123C, 1'b1);
    fetch("R9 masked hit b", 1'b1, 32'h0000_1238, 1'b1);
    fetch("R9 bit1 unmasked", 1'b1, 32'h0000_1232, 1'b0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_novalid();
    fetch("R8 no valid", 1'b0, 32'h0000_1230, 1'b0);
  endtask

  task automatic t_disabled();
    wr(2'd1, 32'h0);
    fetch("R7 disabled", 1'b1, 32'h0000_1230, 1'b0);
    wr(2'd1, 32'h1);
    fetch("R7 re-armed", 1'b1, 32'h0000_1230, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    fetch_vld_i = 1'b0; fetch_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_exact();
    t_bit0();
    t_mask();
    t_novalid();
    t_disabled();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule